// File: doc/BRIEF.md
# Scrambled-Map 64-Source Interrupt Controller

This block gathers up to 64 active-low interrupt lines into two 32-bit register words (an upper word and a lower word). Each source lands on a fixed word and bit chosen by a lookup rule, not by its number. Software reaches the block over a plain register bus. It can enable sources through mask words and acknowledge them by writing ones to the pending words. A sense word switches the external sources and the port sources from level-low to falling-edge detection. A read-only vector register names the most urgent pending enabled source in its top six bits.

The CPU sees one interrupt line. That line is high while any pending bit is also enabled. Priority is fixed: the lowest source number wins. Source number 0 is reserved, because a vector of zero means "nothing pending".

The register bus carries control, not a stream, so it has no valid/ready handshake. A write takes effect at the clock edge where `wr_en` is high. A read returns its data on `rdata` from the edge where `rd_en` is high until the next read.

Top module: `scramble_intc`

## Requirements
- R1: Sources map to words and bits as follows. Source 0 goes to upper bit 0. Sources 1..15 go to upper bit 16−s. Sources 16..18 go to lower bit 18−s. Sources 19..30 go to lower bit 33−s. Source 31 goes to lower bit 0. Sources 32..47 go to upper bit 63−s. Sources 48..63 go to lower bit s−32. Lower bit 0 is shared by sources 18 and 31. Lower bit 15 is never set. A pending bit does not record which source set it, so the vector treats a set shared bit as source 18.
- R2: A mask bit of 1 enables the source at that position and 0 blocks it. Both mask words reset to zero. A masked source still shows in its pending word but raises neither `irq` nor the vector.
- R3: Writing a pending word clears every bit written as 1 and leaves every bit written as 0 unchanged. A set request in the same cycle wins over the clear.
- R4: Each input passes through two synchroniser flops. A source in level mode sets its pending bit at the third clock edge after it goes low. It keeps setting the bit while it stays low, so a clear issued while the input is still low has no lasting effect.
- R5: A source in edge mode sets its pending bit once, on a high-to-low transition. A clear issued while it stays low does take effect. A low-to-high transition sets nothing.
- R6: The sense word holds writable bits only at lower-bit positions 8..14 (sources 25..19) and 16..31 (sources 48..63). For these sources the sense bit sits at the same position as the pending bit. A 1 selects falling edge and a 0 selects level-low. All other sense bits read 0, and all other sources are always level-low. The sense word resets to zero.
- R7: The vector register returns, in bits 31:26, the lowest-numbered source whose pending and mask bits are both set. Bits 25:0 read 0. A value of 0 means nothing is pending.
- R8: `irq` is high exactly when some pending bit is set together with its mask bit.
- R9: Register word offsets are: 0 upper mask, 1 lower mask, 2 upper pending, 3 lower pending, 4 sense, 5 vector. Offsets 6 and 7 read 0. Writes to the vector and to offsets 6 and 7 change nothing.
- R10: The input of source 0 is ignored: upper pending bit 0 never sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_n | input | 64 | Raw interrupt inputs, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
A wrong entry in the source-to-bit rule shows up at the very first read of a pending word: the set bit lands at the wrong position or in the wrong word. A bad pending or mask bit reaches `irq` in the same cycle the register changes. It reaches the vector read one cycle later. A sense bit stuck in the wrong mode shows up within one clear: in level mode the bit is set again at once while the input is low, and in edge mode it stays clear. Priority faults show when several enabled sources are pending at once and the enables are removed one by one.

// File: rtl/intc_map_pkg.sv
package intc_map_pkg;

  localparam int NSRC    = 64;
  localparam int WORD_W  = 32;
  localparam int NWORDS  = 2;
  localparam int ADDR_W  = 3;
  localparam int VEC_W   = $clog2(NSRC);
  localparam int VEC_LSB = WORD_W - VEC_W;

  // word offsets
  localparam logic [ADDR_W-1:0] OFF_MASK_HI = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_MASK_LO = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_PEND_HI = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_PEND_LO = 3'd3;
  localparam logic [ADDR_W-1:0] OFF_SENSE   = 3'd4;
  localparam logic [ADDR_W-1:0] OFF_VECTOR  = 3'd5;

  // word index 0 is the upper word, 1 the lower word
  function automatic int src_word(input int s);
    if (s < 16 || (s >= 32 && s < 48)) return 0;
    return 1;
  endfunction

  function automatic int src_bit(input int s);
    if (s == 0)      return 0;
    else if (s < 16) return 16 - s;
    else if (s < 19) return 18 - s;
    else if (s < 31) return 33 - s;
    else if (s == 31) return 0;
    else if (s < 48) return 63 - s;
    else             return s - 32;
  endfunction

  function automatic bit src_edge_capable(input int s);
    return (s >= 19 && s <= 25) || (s >= 48 && s < NSRC);
  endfunction

  function automatic logic [WORD_W-1:0] sense_wmask();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int s = 0; s < NSRC; s++)
      if (src_edge_capable(s)) m[src_bit(s)] = 1'b1;
    return m;
  endfunction

  localparam logic [WORD_W-1:0] SENSE_WMASK = sense_wmask();

endpackage

// File: rtl/intc_sense_front.sv
module intc_sense_front
  import intc_map_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      src_n,
  input  logic              sense_we,
  input  logic [WORD_W-1:0] sense_wdata,
  output logic [WORD_W-1:0] sense_q,
  output logic [N-1:0]      set_o
);

  logic [N-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q    <= '1;
      s2_q    <= '1;
      s3_q    <= '1;
      sense_q <= '0;
    end else begin
      s1_q <= src_n;
      s2_q <= s1_q;
      s3_q <= s2_q;
      if (sense_we) sense_q <= sense_wdata & SENSE_WMASK;
    end
  end

  for (genvar s = 0; s < N; s++) begin : g_src
    localparam int B = src_bit(s);
    if (s == 0) begin : g_reserved
      assign set_o[s] = 1'b0;
    end else if (src_edge_capable(s)) begin : g_prog
      logic fall;
      assign fall     = s3_q[s] & ~s2_q[s];
      assign set_o[s] = sense_q[B] ? fall : ~s2_q[s];

      // edge mode never requests twice in a row
      assert_edge_single_R5: assert property (@(posedge clk) disable iff (rst)
        (set_o[s] && sense_q[B]) |=> !(set_o[s] && sense_q[B]));
    end else begin : g_level
      assign set_o[s] = ~s2_q[s];
    end
  end

endmodule

// File: rtl/intc_word_bank.sv
module intc_word_bank
  import intc_map_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mask_we,
  input  logic         pend_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] set_v,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] pend_q
);

  logic [W-1:0] clr_v;
  assign clr_v = pend_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      if (mask_we) mask_q <= wdata;
      pend_q <= (pend_q & ~clr_v) | set_v;
    end
  end

  // a pending bit only appears from a set request
  assert_pend_origin_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & ~$past(pend_q | set_v)) == '0));

  // written ones clear unless a set arrives alongside
  assert_pend_clear_R3: assert property (@(posedge clk) disable iff (rst)
    pend_we |=> ((pend_q & $past(clr_v & ~set_v)) == '0));

endmodule

// File: rtl/intc_vec_pick.sv
module intc_vec_pick
  import intc_map_pkg::*;
(
  input  logic [WORD_W-1:0] act_hi,
  input  logic [WORD_W-1:0] act_lo,
  output logic [VEC_W-1:0]  vec_o
);

  always_comb begin
    vec_o = '0;
    for (int s = NSRC - 1; s >= 1; s--) begin
      if (src_word(s) == 0) begin
        if (act_hi[src_bit(s)]) vec_o = VEC_W'(s);
      end else begin
        if (act_lo[src_bit(s)]) vec_o = VEC_W'(s);
      end
    end
  end

endmodule

// File: rtl/scramble_intc.sv
module scramble_intc
  import intc_map_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              irq
);

  logic [NSRC-1:0]   set_src;
  logic [WORD_W-1:0] sense_q;
  logic [WORD_W-1:0] set_w  [NWORDS];
  logic [WORD_W-1:0] mask_w [NWORDS];
  logic [WORD_W-1:0] pend_w [NWORDS];
  logic [WORD_W-1:0] act_w  [NWORDS];
  logic [VEC_W-1:0]  vec;
  logic [WORD_W-1:0] rd_mux;

  intc_sense_front #(.N(NSRC)) u_front (
    .clk         (clk),
    .rst         (rst),
    .src_n       (src_n),
    .sense_we    (wr_en && addr == OFF_SENSE),
    .sense_wdata (wdata),
    .sense_q     (sense_q),
    .set_o       (set_src)
  );

  // fold per-source requests onto word bits
  always_comb begin
    for (int w = 0; w < NWORDS; w++) set_w[w] = '0;
    for (int s = 0; s < NSRC; s++)
      set_w[src_word(s)][src_bit(s)] = set_w[src_word(s)][src_bit(s)] | set_src[s];
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_bank
    intc_word_bank #(.W(WORD_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .mask_we (wr_en && addr == OFF_MASK_HI + ADDR_W'(w)),
      .pend_we (wr_en && addr == OFF_PEND_HI + ADDR_W'(w)),
      .wdata   (wdata),
      .set_v   (set_w[w]),
      .mask_q  (mask_w[w]),
      .pend_q  (pend_w[w])
    );
    assign act_w[w] = pend_w[w] & mask_w[w];
  end

  intc_vec_pick u_pick (
    .act_hi (act_w[0]),
    .act_lo (act_w[1]),
    .vec_o  (vec)
  );

  assign irq = |act_w[0] || |act_w[1];

  always_comb begin
    case (addr)
      OFF_MASK_HI: rd_mux = mask_w[0];
      OFF_MASK_LO: rd_mux = mask_w[1];
      OFF_PEND_HI: rd_mux = pend_w[0];
      OFF_PEND_LO: rd_mux = pend_w[1];
      OFF_SENSE:   rd_mux = sense_q;
      OFF_VECTOR:  rd_mux = {vec, {VEC_LSB{1'b0}}};
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // line and vector agree
  assert_irq_vector_R8: assert property (@(posedge clk) disable iff (rst)
    irq == (vec != '0));

  // upper bit 0 never pends: source 0 is reserved
  assert_src0_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !pend_w[0][0]);

  // unused sense positions stay zero
  assert_sense_bits_R6: assert property (@(posedge clk) disable iff (rst)
    (sense_q & ~SENSE_WMASK) == '0);

  // lower bit 15 has no source
  assert_lo15_unused_R1: assert property (@(posedge clk) disable iff (rst)
    !pend_w[1][15]);

endmodule

// File: tb/scramble_intc_tb.sv
module scramble_intc_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src_n = '1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int bad   = 0;
  logic rd_flag = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  scramble_intc u_dut (
    .clk(clk), .rst(rst), .src_n(src_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // monitor: pop expected read data one cycle after each read strobe
  always @(posedge clk) rd_flag <= rd_en;
  always @(negedge clk) begin
    if (rd_flag) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (rdata !== e) begin
        bad++;
        $display("FAIL %s: got %08h expected %08h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    total++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s: irq got %0b expected %0b", t, irq, e);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle();

    // reset state
    rd(3'd0, 32'h0, "R2 mask_hi reset");
    rd(3'd1, 32'h0, "R2 mask_lo reset");
    rd(3'd2, 32'h0, "R3 pend_hi reset");
    rd(3'd3, 32'h0, "R3 pend_lo reset");
    rd(3'd4, 32'h0, "R6 sense reset");
    rd(3'd5, 32'h0, "R7 vector idle");
    rd(3'd6, 32'h0, "R9 offset 6 reads zero");
    chk_irq(1'b0, "R8 irq reset");

    // source 5 level, upper bit 11
    src_n[5] = 1'b0;
    settle();
    rd(3'd2, 32'h0000_0800, "R1 src5 upper bit11");
    chk_irq(1'b0, "R2 masked source silent");
    rd(3'd5, 32'h0, "R2 masked vector zero");
    wr(3'd0, 32'h0000_0800);
    chk_irq(1'b1, "R8 irq on unmask");
    rd(3'd5, 32'd5 << 26, "R7 vector src5");
    rd(3'd0, 32'h0000_0800, "R2 mask readback");

    // clear while still low: level sets again
    wr(3'd2, 32'h0000_0800);
    rd(3'd2, 32'h0000_0800, "R4 level resets after clear");
    src_n[5] = 1'b1;
    settle();
    wr(3'd2, 32'h0);
    rd(3'd2, 32'h0000_0800, "R3 zero write no effect");
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, 32'h0, "R3 ones clear");
    chk_irq(1'b0, "R8 irq drops after clear");
    wr(3'd0, 32'h0);

    // map spread and priority
    src_n[40] = 1'b0; src_n[50] = 1'b0; src_n[20] = 1'b0; src_n[17] = 1'b0;
    settle();
    rd(3'd2, 32'h0080_0000, "R1 src40 upper bit23");
    rd(3'd3, 32'h0004_2002, "R1 src50 bit18 src20 bit13 src17 bit1");
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd5, 32'd17 << 26, "R7 lowest wins 17");
    wr(3'd1, 32'hFFFF_FFFD);
    rd(3'd5, 32'd20 << 26, "R7 next 20");
    wr(3'd1, 32'hFFFF_DFFD);
    rd(3'd5, 32'd40 << 26, "R7 upper 40 before 50");
    wr(3'd0, 32'h0);
    rd(3'd5, 32'd50 << 26, "R7 only 50 left");
    src_n[40] = 1'b1; src_n[50] = 1'b1; src_n[20] = 1'b1; src_n[17] = 1'b1;
    settle();
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd1, 32'h0);
    chk_irq(1'b0, "R8 irq idle after cleanup");

    // sense word and edge mode on source 50
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, 32'hFFFF_7F00, "R6 sense writable bits");
    wr(3'd4, 32'h0004_0000);
    src_n[50] = 1'b0;
    settle();
    rd(3'd3, 32'h0004_0000, "R5 falling edge sets");
    wr(3'd3, 32'h0004_0000);
    settle();
    rd(3'd3, 32'h0, "R5 clear holds while low");
    src_n[50] = 1'b1;
    settle();
    rd(3'd3, 32'h0, "R5 rising edge ignored");
    src_n[50] = 1'b0;
    settle();
    rd(3'd3, 32'h0004_0000, "R5 second fall sets");
    src_n[50] = 1'b1;
    settle();
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd4, 32'h0);

    // reserved source 0
    wr(3'd0, 32'hFFFF_FFFF);
    src_n[0] = 1'b0;
    settle();
    rd(3'd2, 32'h0, "R10 source 0 ignored");
    chk_irq(1'b0, "R10 no irq from source 0");
    src_n[0] = 1'b1;
    wr(3'd0, 32'h0);

    // shared lower bit 0 via source 31
    src_n[31] = 1'b0;
    settle();
    rd(3'd3, 32'h0000_0001, "R1 src31 lower bit0");
    wr(3'd1, 32'h0000_0001);
    rd(3'd5, 32'd18 << 26, "R1 shared bit reports 18");
    src_n[31] = 1'b1;
    settle();
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd1, 32'h0);

    // writes to read-only and unused offsets
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd5, 32'h0, "R9 vector write ignored");
    rd(3'd0, 32'h0, "R9 mask_hi untouched");
    rd(3'd1, 32'h0, "R9 mask_lo untouched");
    rd(3'd7, 32'h0, "R9 offset 7 reads zero");

    finish_run();
  end

endmodule